// File: doc/BRIEF.md
# Serial Receiver Status Flags

This block holds the receive data register and the status flags of an asynchronous serial receiver. It also raises the receiver interrupt request. An external shifter supplies four things: a strobe when a word completes, the word itself, the sampled stop bit and a noise indication. On every bit time it also gives a tick together with the current line level. Software-side read strobes for the status and data registers drive the flag clearing. Two enable bits gate the interrupt.

A completed word moves into the data register only while that register is free. When the register is still full, the new word is dropped and an overrun is recorded. Every flag clears through the same two-step access: first a status read, then a data read. Only flags that were already set at the moment of the status read are cleared. Idle is detected from a run of logic-one bit times on the line, and it is re-armed by each received word.

Top module: `rxs_status_top`

## Requirements
- R1: When `word_done` is high and the data-full flag is clear (after any clear taking effect in that same cycle), the next cycle shows `rdata` equal to `word_data` and `flag_rdf` at 1.
- R2: `flag_rdf` falls only on a data read that follows a status read made while it was 1. A data read with no prior status read leaves it set.
- R3: A status read arms clearing only for the flags that are set in that cycle. A flag that sets after the status read survives the next data read.
- R4: When `word_done` is high while the data-full flag stays set, `flag_ovr` becomes 1 and `rdata` keeps its previous contents.
- R5: The word dropped on overrun changes neither `flag_fe` nor `flag_nf`, even when its stop bit is 0 or noise is reported.
- R6: For an accepted word, `flag_fe` takes the value of the inverted `stop_bit`.
- R7: For an accepted word, `flag_nf` takes the value of `noise_det`.
- R8: The idle flag sets on the `bit_tick` that completes a run of consecutive ones. The run is IDLE_SHORT ones (10 by default) with `long_frame`=0 and IDLE_LONG ones (11) with `long_frame`=1. A tick with the line at 0 restarts the run.
- R9: After idle has been detected, it is not detected again until a `word_done` has occurred. The run count saturates, so the first one-tick after that word can set idle again.
- R10: `irq` is 1 exactly when (`rx_ie` and (`flag_rdf` or `flag_ovr`)) or (`idle_ie` and `flag_idle`).
- R11: While `rst_n` is low, all flags, the armed clear state and `rdata` are 0, and idle detection is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_done | input | 1 | Shifter has completed a word this cycle |
| word_data | input | DATA_W | Completed word from the shifter |
| stop_bit | input | 1 | Sampled stop bit of the completed word |
| noise_det | input | 1 | Shifter saw noise on the completed word |
| bit_tick | input | 1 | One pulse per bit time |
| line_level | input | 1 | Receive line level at the bit tick |
| long_frame | input | 1 | 1 selects the longer frame (longer idle run) |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| rx_ie | input | 1 | Receive and overrun interrupt enable |
| idle_ie | input | 1 | Idle interrupt enable |
| rdata | output | DATA_W | Data register contents |
| flag_rdf | output | 1 | Receive data full |
| flag_idle | output | 1 | Line idle detected |
| flag_ovr | output | 1 | Overrun |
| flag_nf | output | 1 | Noise on the held word |
| flag_fe | output | 1 | Framing error on the held word |
| irq | output | 1 | Combined receiver interrupt request |

## Verification
The bench builds the block with DATA_W=9, so the top data bit matters, and keeps IDLE_SHORT=10 and IDLE_LONG=11. These values let both idle run lengths be reached within a few dozen bit ticks. They also let the run counter reach saturation while idle detection is disarmed, which shows re-arming on a word. A long pseudo-random phase mixes word strobes and register reads. That mix places overruns, same-cycle clear-and-load, and status reads racing new flags within reach of the per-cycle model.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int NFLAG  = 5;
    localparam int F_RDF  = 0;
    localparam int F_IDLE = 1;
    localparam int F_OVR  = 2;
    localparam int F_NF   = 3;
    localparam int F_FE   = 4;

    typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/rxs_idle_det.sv
module rxs_idle_det #(
    parameter int IDLE_SHORT = 10,
    parameter int IDLE_LONG  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic line_level,
    input  logic long_frame,
    input  logic word_done,
    output logic idle_hit
);
    localparam int CW = $clog2(IDLE_LONG + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          en;
    } idle_st_t;

    idle_st_t st_d, st_q;
    logic [CW-1:0] thr;

    always_comb begin
        st_d     = st_q;
        idle_hit = 1'b0;
        thr      = long_frame ? CW'(IDLE_LONG) : CW'(IDLE_SHORT);
        if (bit_tick) begin
            if (line_level) begin
                if (st_q.cnt < CW'(IDLE_LONG)) st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.en && (st_d.cnt >= thr)) begin
                    idle_hit = 1'b1;
                    st_d.en  = 1'b0;
                end
            end else begin
                st_d.cnt = '0;
            end
        end
        if (word_done) st_d.en = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.en  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    idle_on_high_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_hit |-> (bit_tick && line_level));

    // R9
    idle_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_hit && !word_done) |=> !idle_hit);
endmodule

// File: rtl/rxs_rdr.sv
module rxs_rdr
    import rxs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [DATA_W-1:0] word_data,
    input  logic              stop_bit,
    input  logic              noise_det,
    input  logic              idle_hit,
    input  logic              stat_rd,
    input  logic              data_rd,
    output logic [DATA_W-1:0] data_out,
    output flag_vec_t         flags_out
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        flag_vec_t         flags;
        flag_vec_t         arm;
    } rdr_st_t;

    rdr_st_t   st_d, st_q;
    flag_vec_t clr;
    logic      rdf_busy;

    always_comb begin
        st_d     = st_q;
        clr      = data_rd ? st_q.arm : '0;
        st_d.flags = st_q.flags & ~clr;
        rdf_busy = st_d.flags[F_RDF];
        if (word_done) begin
            if (rdf_busy) begin
                st_d.flags[F_OVR] = 1'b1;
            end else begin
                st_d.data         = word_data;
                st_d.flags[F_RDF] = 1'b1;
                st_d.flags[F_FE]  = ~stop_bit;
                st_d.flags[F_NF]  = noise_det;
            end
        end
        if (idle_hit) st_d.flags[F_IDLE] = 1'b1;
        if (stat_rd)      st_d.arm = st_q.flags;
        else if (data_rd) st_d.arm = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_out  = st_q.data;
    assign flags_out = st_q.flags;

    // R1
    load_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !rdf_busy) |=> (st_q.data == $past(word_data)) && st_q.flags[F_RDF]);

    // R4
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && rdf_busy) |=> st_q.flags[F_OVR] && $stable(st_q.data));

    // R5
    ovr_fe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && rdf_busy) |=> !(st_q.flags[F_FE] && !$past(st_q.flags[F_FE])));

    // R2
    rdf_clear_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flags[F_RDF]) |-> $past(data_rd && st_q.arm[F_RDF]));
endmodule

// File: rtl/rxs_status_top.sv
module rxs_status_top
    import rxs_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int IDLE_SHORT = 10,
    parameter int IDLE_LONG  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [DATA_W-1:0] word_data,
    input  logic              stop_bit,
    input  logic              noise_det,
    input  logic              bit_tick,
    input  logic              line_level,
    input  logic              long_frame,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              rx_ie,
    input  logic              idle_ie,
    output logic [DATA_W-1:0] rdata,
    output logic              flag_rdf,
    output logic              flag_idle,
    output logic              flag_ovr,
    output logic              flag_nf,
    output logic              flag_fe,
    output logic              irq
);
    logic      idle_hit;
    flag_vec_t flags;

    rxs_idle_det #(
        .IDLE_SHORT (IDLE_SHORT),
        .IDLE_LONG  (IDLE_LONG)
    ) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .line_level (line_level),
        .long_frame (long_frame),
        .word_done  (word_done),
        .idle_hit   (idle_hit)
    );

    rxs_rdr #(
        .DATA_W (DATA_W)
    ) u_rdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_done (word_done),
        .word_data (word_data),
        .stop_bit  (stop_bit),
        .noise_det (noise_det),
        .idle_hit  (idle_hit),
        .stat_rd   (stat_rd),
        .data_rd   (data_rd),
        .data_out  (rdata),
        .flags_out (flags)
    );

    assign flag_rdf  = flags[F_RDF];
    assign flag_idle = flags[F_IDLE];
    assign flag_ovr  = flags[F_OVR];
    assign flag_nf   = flags[F_NF];
    assign flag_fe   = flags[F_FE];

    always_comb begin
        irq = (rx_ie && (flag_rdf || flag_ovr)) || (idle_ie && flag_idle);
    end

    // R10
    irq_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ie && flag_ovr) |-> irq);

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !idle_ie) |-> !irq);

    // R8
    idle_from_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_idle) |-> $past(idle_hit));
endmodule

// File: tb/sim_rxs_status_top.sv
module sim_rxs_status_top;
    localparam int DW = 9;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, word_done, stop_bit, noise_det, bit_tick, line_level;
    logic long_frame, stat_rd, data_rd, rx_ie, idle_ie;
    logic [DW-1:0] word_data;
    logic [DW-1:0] rdata;
    logic flag_rdf, flag_idle, flag_ovr, flag_nf, flag_fe, irq;

    int errs = 0, checks = 0;
    bit done = 0;

    rxs_status_top #(.DATA_W(DW), .IDLE_SHORT(10), .IDLE_LONG(11)) u0 (
        .clk(clk), .rst_n(rst_n), .word_done(word_done), .word_data(word_data),
        .stop_bit(stop_bit), .noise_det(noise_det), .bit_tick(bit_tick),
        .line_level(line_level), .long_frame(long_frame), .stat_rd(stat_rd),
        .data_rd(data_rd), .rx_ie(rx_ie), .idle_ie(idle_ie), .rdata(rdata),
        .flag_rdf(flag_rdf), .flag_idle(flag_idle), .flag_ovr(flag_ovr),
        .flag_nf(flag_nf), .flag_fe(flag_fe), .irq(irq)
    );

    // Behavioural reference model
    logic [DW-1:0] m_data;
    logic m_rdf, m_idle, m_ovr, m_nf, m_fe, m_en;
    logic [4:0] m_arm;
    int m_cnt;

    always @(posedge clk) begin : model
        logic [4:0] clr;
        logic r, i, o, n, f;
        if (!rst_n) begin
            m_data = '0; m_rdf = 0; m_idle = 0; m_ovr = 0; m_nf = 0; m_fe = 0;
            m_arm = '0; m_en = 1; m_cnt = 0;
        end else begin
            clr = data_rd ? m_arm : 5'b0;
            r = m_rdf & ~clr[0]; i = m_idle & ~clr[1]; o = m_ovr & ~clr[2];
            n = m_nf & ~clr[3];  f = m_fe & ~clr[4];
            if (word_done) begin
                if (r) o = 1;
                else begin
                    m_data = word_data; r = 1; f = !stop_bit; n = noise_det;
                end
            end
            if (bit_tick) begin
                if (line_level) begin
                    if (m_cnt < 11) m_cnt = m_cnt + 1;
                    if (m_en && m_cnt >= (long_frame ? 11 : 10)) begin
                        i = 1; m_en = 0;
                    end
                end else m_cnt = 0;
            end
            if (word_done) m_en = 1;
            if (stat_rd) m_arm = {m_fe, m_nf, m_ovr, m_idle, m_rdf};
            else if (data_rd) m_arm = '0;
            m_rdf = r; m_idle = i; m_ovr = o; m_nf = n; m_fe = f;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk("R1 rdata", 32'(rdata), 32'(m_data));
        chk("R2 flag_rdf", 32'(flag_rdf), 32'(m_rdf));
        chk("R4 flag_ovr", 32'(flag_ovr), 32'(m_ovr));
        chk("R6 flag_fe", 32'(flag_fe), 32'(m_fe));
        chk("R7 flag_nf", 32'(flag_nf), 32'(m_nf));
        chk("R8 flag_idle", 32'(flag_idle), 32'(m_idle));
        chk("R10 irq", 32'(irq),
            32'((rx_ie && (m_rdf || m_ovr)) || (idle_ie && m_idle)));
    endtask

    task automatic step(input logic wd, input logic [DW-1:0] wdat, input logic sb,
                        input logic nz, input logic tk, input logic ln,
                        input logic sr, input logic dr);
        word_done = wd; word_data = wdat; stop_bit = sb; noise_det = nz;
        bit_tick = tk; line_level = ln; stat_rd = sr; data_rd = dr;
        @(posedge clk);
        @(negedge clk);
        cmp_all();
    endtask

    task automatic idle_c(); step(0, '0, 1, 0, 0, 1, 0, 0); endtask
    task automatic word_c(input logic [DW-1:0] d, input logic sb, input logic nz);
        step(1, d, sb, nz, 0, 1, 0, 0);
    endtask
    task automatic srd(); step(0, '0, 1, 0, 0, 1, 1, 0); endtask
    task automatic drd(); step(0, '0, 1, 0, 0, 1, 0, 1); endtask
    task automatic tick(input logic ln); step(0, '0, 1, 0, 1, ln, 0, 0); endtask

    logic [31:0] lfsr = 32'h1ACE_B00C;
    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        #(150000 * 10);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; word_done = 0; word_data = '0; stop_bit = 1; noise_det = 0;
        bit_tick = 0; line_level = 1; long_frame = 0; stat_rd = 0; data_rd = 0;
        rx_ie = 1; idle_ie = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        chk("R11 rdata", 32'(rdata), 0);
        chk("R11 flags", 32'({flag_rdf, flag_idle, flag_ovr, flag_nf, flag_fe}), 0);
        chk("R11 irq", 32'(irq), 0);

        word_c(9'h055, 1, 0);
        chk("R1 load", 32'({flag_rdf, rdata}), 32'({1'b1, 9'h055}));
        srd();
        word_c(9'h1AA, 0, 1);
        chk("R4 ovr", 32'({flag_ovr, rdata}), 32'({1'b1, 9'h055}));
        chk("R5 fe/nf untouched", 32'({flag_fe, flag_nf}), 0);
        drd();
        chk("R3 late ovr kept", 32'({flag_rdf, flag_ovr}), 32'(2'b01));
        srd(); drd();
        chk("R3 ovr cleared", 32'(flag_ovr), 0);

        word_c(9'h1F0, 0, 1);
        chk("R6 fe", 32'(flag_fe), 1);
        chk("R7 nf", 32'(flag_nf), 1);
        chk("R1 top bit", 32'(rdata), 32'h1F0);
        drd();
        chk("R2 data read alone", 32'(flag_rdf), 1);
        srd(); drd();
        chk("R2 seq clear", 32'({flag_rdf, flag_fe, flag_nf}), 0);

        tick(0);
        for (int k = 0; k < 9; k++) tick(1);
        chk("R8 nine ones", 32'(flag_idle), 0);
        tick(1);
        chk("R8 ten ones", 32'(flag_idle), 1);
        chk("R10 idle irq", 32'(irq), 1);
        srd(); drd();
        for (int k = 0; k < 15; k++) tick(1);
        chk("R9 no rearm", 32'(flag_idle), 0);
        word_c(9'h011, 1, 0);
        tick(1);
        chk("R9 rearmed", 32'(flag_idle), 1);
        srd(); drd();

        long_frame = 1;
        step(1, 9'h022, 1, 0, 1, 0, 0, 0);
        for (int k = 0; k < 10; k++) tick(1);
        chk("R8 long ten", 32'(flag_idle), 0);
        tick(1);
        chk("R8 long eleven", 32'(flag_idle), 1);
        rx_ie = 0; idle_ie = 0;
        idle_c();
        chk("R10 masked", 32'(irq), 0);
        rx_ie = 1;
        idle_c();
        chk("R10 rx enabled", 32'(irq), 1);
        idle_ie = 1;
        srd(); drd();

        for (int c = 0; c < 6000; c++) begin
            logic run;
            lfsr = nxt(lfsr);
            run = (c % 400) < 60;
            long_frame = lfsr[20];
            if (lfsr[25:24] == 2'b00) begin
                rx_ie = lfsr[26]; idle_ie = lfsr[27];
            end
            step((lfsr[4:0] == 5'd3), lfsr[16:8], lfsr[17], lfsr[18],
                 (lfsr[6:5] == 2'b00) || run, run ? 1'b1 : lfsr[19],
                 (lfsr[29:27] == 3'd1), (lfsr[31:29] == 3'd2));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule